// File: doc/BRIEF.md
# Host Adapter Vendor Command Processor

This block executes the vendor-specific command set of a storage host adapter. A host writes an opcode byte with one strobe and its parameter bytes with another, both on a shared byte-wide write bus. The block knows how many parameter bytes each opcode needs. It gathers them into a parameter buffer and runs the command in the cycle after the last byte arrives. Commands that answer the host load a reply counter. The host then pops reply bytes from a data-out port, one per read strobe, while a data-ready flag is high.

The block holds a 256-byte configuration image in flip-flops, which the host can write and read in blocks. Block addresses wrap modulo 256. The block also keeps a mailbox-interface lock bit, a latched mailbox-init record (entry count and 24-bit address), an init-pending status bit, an invalid-command flag and an interrupt code register. A parameter selects whether the configuration image exists.

The controller has five states. S_IDLE waits for an opcode. S_COLLECT gathers parameter bytes. S_EXEC is a single cycle that performs the decoded command. S_NVWR stores image bytes, one per cycle. S_REPLY presents reply bytes until the host has taken them all. The transitions are as follows:
- An opcode strobe in any state goes to S_COLLECT, or to S_EXEC when the opcode takes no parameters.
- S_COLLECT goes to S_EXEC on the last parameter byte.
- S_EXEC goes to S_NVWR for an image write that has data bytes, to S_REPLY for a command that has reply bytes, and to S_IDLE otherwise.
- S_NVWR goes to S_IDLE after its last byte.
- S_REPLY goes to S_IDLE on the pop of its last byte.

Top module: `vcmd_proc`

## Requirements
- R1: After reset, data_rdy, busy, inv_cmd, mbox_lock and mbox_inited are 0, intr_code is 0x00, init_stat is 1, data_out is 0x00, and mbox_count and mbox_addr are 0.
- R2: The parameter byte counts are as follows: 0x22 takes 35, 0x23 takes 3, 0x24 takes 1, 0x25 takes 4, 0x29 takes 2, and every other opcode takes 0. busy is 1 from the cycle after the opcode until the command has finished. A parameter strobe while no opcode is collecting parameters has no effect.
- R3: Opcode 0x22 has parameters p0 (ignored), p1 = length and p2 = offset, followed by data bytes d0..d31. Image byte (p2+i) mod 256 receives d_i for i below min(p1, 32). No other image byte changes, and the command produces no reply and does not set inv_cmd.
- R4: Opcode 0x23 has parameters p0 (ignored), p1 = length and p2 = offset. It offers p1 reply bytes, the i-th being image byte (p2+i) mod 256. Length 0 gives no reply.
- R5: When the block is built without the image (HAS_NV = 0), opcodes 0x22 and 0x23 set inv_cmd and produce no reply.
- R6: Opcode 0x28 replies with two bytes: first 0x08, then the lock bit as 0x00 or 0x01.
- R7: Opcode 0x29 has parameters p0 and p1. If p1 equals the current lock value (0x00 or 0x01), the lock becomes bit 0 of p0. Otherwise the lock keeps its value. The opcode gives no reply, and no other opcode changes the lock.
- R8: Opcode 0x25 has parameters p0..p3. It sets mbox_count to p0, mbox_addr to {p1,p2,p3} with p1 as the most significant byte, sets mbox_inited and clears init_stat.
- R9: Opcode 0x2C replies with one 0x00 byte. Any opcode outside the set 0x22, 0x23, 0x24, 0x25, 0x28, 0x29, 0x2C sets inv_cmd and gives no reply.
- R10: Opcode 0x24 loads intr_code with 0x04 and gives no reply.
- R11: An opcode strobe in any state drops any unread reply, clears inv_cmd and intr_code, and restarts parameter collection for the new opcode. The opcode strobe takes priority over a parameter or read strobe in the same cycle.
- R12: data_out shows the current reply byte while data_rdy is 1, and 0x00 otherwise. Each data_rd while data_rdy is 1 advances to the next byte. data_rdy falls after the last byte, and a data_rd while data_rdy is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_wr | input | 1 | Strobe: wr_byte is an opcode |
| par_wr | input | 1 | Strobe: wr_byte is a parameter byte |
| wr_byte | input | 8 | Opcode or parameter byte |
| data_rd | input | 1 | Pop one reply byte |
| data_out | output | 8 | Current reply byte |
| data_rdy | output | 1 | Reply bytes remain |
| busy | output | 1 | Command collecting or executing |
| inv_cmd | output | 1 | Invalid-command status |
| init_stat | output | 1 | Mailbox initialization pending |
| intr_code | output | 8 | Interrupt code register |
| mbox_lock | output | 1 | Mailbox-interface lock |
| mbox_inited | output | 1 | Mailbox-init record latched |
| mbox_count | output | 8 | Latched mailbox entry count |
| mbox_addr | output | 24 | Latched mailbox address |

## Verification
The bench builds two instances that share stimulus. The first uses the default parameters, with an 8-bit image address and HAS_NV = 1. With this configuration every image byte can be written through wrapping block writes, including a write longer than the 32-byte data field, and then read back in full from several starting offsets. The second instance uses HAS_NV = 0 and exposes the invalid-command path of the image opcodes. Beyond the image, the bench sweeps all 256 opcode values for the invalid-command rule and every combination of current lock, echoed value and requested bit for the lock rule.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COLLECT,
        S_EXEC,
        S_NVWR,
        S_REPLY
    } vstate_e;

    typedef enum logic [1:0] {
        SRC_NV,
        SRC_INFO,
        SRC_ZERO
    } rsrc_e;

    localparam logic [7:0] OP_NVWR   = 8'h22;
    localparam logic [7:0] OP_NVRD   = 8'h23;
    localparam logic [7:0] OP_SHADOW = 8'h24;
    localparam logic [7:0] OP_MBINIT = 8'h25;
    localparam logic [7:0] OP_INFO   = 8'h28;
    localparam logic [7:0] OP_LOCK   = 8'h29;
    localparam logic [7:0] OP_PROBE  = 8'h2C;

    localparam int PMAX     = 35;
    localparam int NV_HDR   = 3;
    localparam int NV_DMAX  = PMAX - NV_HDR;
    localparam int CW       = $clog2(PMAX + 1);

    localparam logic [7:0] INFO_TAG   = 8'h08;
    localparam logic [7:0] SHADOW_ACK = 8'h04;

endpackage

// File: rtl/vcmd_opdec.sv
module vcmd_opdec
    import vcmd_pkg::*;
(
    input  logic [7:0]    opcode,
    output logic [CW-1:0] plen
);
    always_comb begin
        case (opcode)
            OP_NVWR:   plen = CW'(PMAX);
            OP_NVRD:   plen = CW'(3);
            OP_SHADOW: plen = CW'(1);
            OP_MBINIT: plen = CW'(4);
            OP_LOCK:   plen = CW'(2);
            default:   plen = '0;
        endcase
    end
endmodule

// File: rtl/vcmd_nvram.sv
module vcmd_nvram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vcmd_reply.sv
module vcmd_reply
    import vcmd_pkg::*;
(
    input  logic       rdy,
    input  rsrc_e      src,
    input  logic       second,
    input  logic [7:0] nv_byte,
    input  logic       lock,
    output logic [7:0] dout
);
    always_comb begin
        dout = 8'h00;
        if (rdy) begin
            unique case (src)
                SRC_NV:   dout = nv_byte;
                SRC_INFO: dout = second ? {7'b0, lock} : INFO_TAG;
                SRC_ZERO: dout = 8'h00;
                default:  dout = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/vcmd_proc.sv
module vcmd_proc
    import vcmd_pkg::*;
#(
    parameter int HAS_NV = 1,
    parameter int NV_AW  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_wr,
    input  logic        par_wr,
    input  logic [7:0]  wr_byte,
    input  logic        data_rd,
    output logic [7:0]  data_out,
    output logic        data_rdy,
    output logic        busy,
    output logic        inv_cmd,
    output logic        init_stat,
    output logic [7:0]  intr_code,
    output logic        mbox_lock,
    output logic        mbox_inited,
    output logic [7:0]  mbox_count,
    output logic [23:0] mbox_addr
);
    localparam int WW = $clog2(NV_DMAX + 1);

    vstate_e          state, state_nx;
    logic [7:0]       op_q;
    logic [CW-1:0]    plen_q, pcnt, dec_len;
    logic [7:0]       pbuf [PMAX];
    logic [7:0]       rcnt;
    logic [NV_AW-1:0] rptr;
    logic             ridx;
    rsrc_e            rsrc;
    logic [WW-1:0]    widx, nwr_q, nwr_calc;
    logic             nv_we;
    logic [NV_AW-1:0] nv_waddr;
    logic [7:0]       nv_wdata, nv_rdata;

    vcmd_opdec u_dec (.opcode(wr_byte), .plen(dec_len));

    assign nwr_calc = (pbuf[1] > 8'(NV_DMAX)) ? WW'(NV_DMAX) : WW'(pbuf[1]);
    assign nv_we    = (state == S_NVWR);
    assign nv_waddr = pbuf[2][NV_AW-1:0] + NV_AW'(widx);
    assign nv_wdata = pbuf[CW'(widx) + CW'(NV_HDR)];

    generate
        if (HAS_NV != 0) begin : g_nv
            vcmd_nvram #(.AW(NV_AW), .DW(8)) u_nv (
                .clk(clk), .rst_n(rst_n), .we(nv_we), .waddr(nv_waddr),
                .wdata(nv_wdata), .raddr(rptr), .rdata(nv_rdata)
            );
        end else begin : g_no_nv
            assign nv_rdata = 8'h00;
        end
    endgenerate

    assign data_rdy = (rcnt != 8'd0);
    assign busy     = (state == S_COLLECT) || (state == S_EXEC) || (state == S_NVWR);

    vcmd_reply u_rep (
        .rdy(data_rdy), .src(rsrc), .second(ridx), .nv_byte(nv_rdata),
        .lock(mbox_lock), .dout(data_out)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (op_wr) begin
            state_nx = (dec_len == '0) ? S_EXEC : S_COLLECT;
        end else begin
            unique case (state)
                S_IDLE:    state_nx = S_IDLE;
                S_COLLECT: if (par_wr && (pcnt == plen_q - CW'(1))) state_nx = S_EXEC;
                S_EXEC: begin
                    state_nx = S_IDLE;
                    case (op_q)
                        OP_NVWR:  if (HAS_NV != 0 && nwr_calc != '0) state_nx = S_NVWR;
                        OP_NVRD:  if (HAS_NV != 0 && pbuf[1] != 8'd0) state_nx = S_REPLY;
                        OP_INFO,
                        OP_PROBE: state_nx = S_REPLY;
                        default:  state_nx = S_IDLE;
                    endcase
                end
                S_NVWR:    if (widx == nwr_q - WW'(1)) state_nx = S_IDLE;
                S_REPLY:   if (data_rd && rcnt == 8'd1) state_nx = S_IDLE;
                default:   state_nx = S_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= 8'h00;
            plen_q      <= '0;
            pcnt        <= '0;
            for (int i = 0; i < PMAX; i++) pbuf[i] <= 8'h00;
            rcnt        <= 8'd0;
            rptr        <= '0;
            ridx        <= 1'b0;
            rsrc        <= SRC_ZERO;
            widx        <= '0;
            nwr_q       <= '0;
            inv_cmd     <= 1'b0;
            init_stat   <= 1'b1;
            intr_code   <= 8'h00;
            mbox_lock   <= 1'b0;
            mbox_inited <= 1'b0;
            mbox_count  <= 8'h00;
            mbox_addr   <= 24'h0;
        end else if (op_wr) begin
            op_q      <= wr_byte;
            plen_q    <= dec_len;
            pcnt      <= '0;
            rcnt      <= 8'd0;
            widx      <= '0;
            inv_cmd   <= 1'b0;
            intr_code <= 8'h00;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_COLLECT: if (par_wr) begin
                    pbuf[pcnt] <= wr_byte;
                    pcnt       <= pcnt + CW'(1);
                end
                S_EXEC: begin
                    case (op_q)
                        OP_NVWR: begin
                            if (HAS_NV == 0) inv_cmd <= 1'b1;
                            widx  <= '0;
                            nwr_q <= nwr_calc;
                        end
                        OP_NVRD: begin
                            if (HAS_NV == 0) begin
                                inv_cmd <= 1'b1;
                            end else begin
                                rcnt <= pbuf[1];
                                rptr <= pbuf[2][NV_AW-1:0];
                                rsrc <= SRC_NV;
                            end
                        end
                        OP_SHADOW: intr_code <= SHADOW_ACK;
                        OP_MBINIT: begin
                            mbox_count  <= pbuf[0];
                            mbox_addr   <= {pbuf[1], pbuf[2], pbuf[3]};
                            mbox_inited <= 1'b1;
                            init_stat   <= 1'b0;
                        end
                        OP_INFO: begin
                            rcnt <= 8'd2;
                            ridx <= 1'b0;
                            rsrc <= SRC_INFO;
                        end
                        OP_LOCK: if (pbuf[1] == {7'b0, mbox_lock}) mbox_lock <= pbuf[0][0];
                        OP_PROBE: begin
                            rcnt <= 8'd1;
                            rsrc <= SRC_ZERO;
                        end
                        default: inv_cmd <= 1'b1;
                    endcase
                end
                S_NVWR: widx <= widx + WW'(1);
                S_REPLY: if (data_rd) begin
                    rcnt <= rcnt - 8'd1;
                    rptr <= rptr + NV_AW'(1);
                    ridx <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Assertions
    AST_RDY_ONLY_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_REPLY) |-> !data_rdy); // R12
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && data_rdy && !op_wr) |=> (rcnt == $past(rcnt) - 8'd1)); // R12
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr || !(state == S_EXEC && op_q == OP_LOCK)) |=> $stable(mbox_lock)); // R7
    AST_INIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_inited |-> !init_stat); // R8
    AST_BUSY_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !data_rdy); // R2
    AST_NVWR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NVWR) |-> (widx < nwr_q && nwr_q <= WW'(NV_DMAX))); // R3

endmodule

// File: tb/tb_vcmd_proc.sv
module tb_vcmd_proc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_wr = 1'b0, par_wr = 1'b0, data_rd = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic [7:0]  data_out, n_data_out, intr_code, n_intr_code, mbox_count, n_mbox_count;
    logic        data_rdy, busy, inv_cmd, init_stat, mbox_lock, mbox_inited;
    logic        n_data_rdy, n_busy, n_inv_cmd, n_init_stat, n_mbox_lock, n_mbox_inited;
    logic [23:0] mbox_addr, n_mbox_addr;

    always #2.5 clk = ~clk;

    vcmd_proc #(.HAS_NV(1), .NV_AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .par_wr(par_wr), .wr_byte(wr_byte),
        .data_rd(data_rd), .data_out(data_out), .data_rdy(data_rdy), .busy(busy),
        .inv_cmd(inv_cmd), .init_stat(init_stat), .intr_code(intr_code),
        .mbox_lock(mbox_lock), .mbox_inited(mbox_inited), .mbox_count(mbox_count),
        .mbox_addr(mbox_addr));

    vcmd_proc #(.HAS_NV(0), .NV_AW(8)) dut_nonv (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .par_wr(par_wr), .wr_byte(wr_byte),
        .data_rd(data_rd), .data_out(n_data_out), .data_rdy(n_data_rdy), .busy(n_busy),
        .inv_cmd(n_inv_cmd), .init_stat(n_init_stat), .intr_code(n_intr_code),
        .mbox_lock(n_mbox_lock), .mbox_inited(n_mbox_inited), .mbox_count(n_mbox_count),
        .mbox_addr(n_mbox_addr));

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] model [256];
    logic [7:0] pb [35];
    logic       lock_m = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_op(input logic [7:0] b);
        @(negedge clk); op_wr = 1'b1; wr_byte = b;
        @(negedge clk); op_wr = 1'b0;
    endtask

    task automatic send_par(input logic [7:0] b);
        @(negedge clk); par_wr = 1'b1; wr_byte = b;
        @(negedge clk); par_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic cmd(input logic [7:0] op, input int np);
        send_op(op);
        for (int i = 0; i < np; i++) send_par(pb[i]);
        wait_idle();
    endtask

    task automatic pop(output logic [7:0] v);
        v = data_out;
        data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic nv_write(input logic [7:0] len, input logic [7:0] off, input int seed);
        pb[0] = 8'h00; pb[1] = len; pb[2] = off;
        for (int i = 0; i < 32; i++) pb[3 + i] = 8'((seed + i * 13) & 255);
        cmd(8'h22, 35);
        for (int i = 0; i < 32; i++)
            if (i < int'(len)) model[8'(int'(off) + i)] = pb[3 + i];
    endtask

    task automatic set_lock(input logic [7:0] p0, input logic [7:0] p1);
        pb[0] = p0; pb[1] = p1;
        cmd(8'h29, 2);
        if (p1 == {7'b0, lock_m}) lock_m = p0[0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int errs;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 data_rdy", data_rdy, 0);
        chk("R1 busy", busy, 0);
        chk("R1 inv_cmd", inv_cmd, 0);
        chk("R1 init_stat", init_stat, 1);
        chk("R1 intr_code", intr_code, 0);
        chk("R1 lock", mbox_lock, 0);
        chk("R1 inited/count/addr", {mbox_inited, mbox_count, mbox_addr}, 0);
        chk("R1 data_out", data_out, 0);

        // R2 busy while collecting, stray params ignored
        send_op(8'h23); send_par(8'h00); send_par(8'h01);
        chk("R2 busy mid-collect", busy, 1);
        chk("R2 no reply mid-collect", data_rdy, 0);
        send_par(8'h00); wait_idle();
        chk("R2 busy after last param", busy, 0);
        chk("R2 read len1 ready", data_rdy, 1);
        pop(v);
        send_par(8'h55); send_par(8'h77);
        chk("R2 stray param busy", busy, 0);
        chk("R2 stray param rdy", data_rdy, 0);

        // R3 wrapping block writes covering whole image
        for (int k = 0; k < 8; k++) begin
            nv_write(8'd32, 8'(8'hF0 + k * 32), 17 * k + 3);
            chk("R3 write no reply", data_rdy, 0);
            chk("R3 write no inv", inv_cmd, 0);
        end
        // R3 length clamp to 32
        nv_write(8'd40, 8'h40, 200);

        // R4 read-back sweep from several offsets
        for (int s = 0; s < 3; s++) begin
            logic [7:0] off;
            off = (s == 0) ? 8'h00 : (s == 1) ? 8'h81 : 8'hFF;
            pb[0] = 8'h00; pb[1] = 8'd255; pb[2] = off;
            cmd(8'h23, 3);
            errs = 0;
            for (int i = 0; i < 255; i++) begin
                if (i == 254) chk("R12 rdy before last pop", data_rdy, 1);
                pop(v);
                if (v !== model[8'(int'(off) + i)]) begin
                    errs++;
                    $display("FAIL R4 byte %0d: actual %0h expected %0h", i, v, model[8'(int'(off) + i)]);
                end
            end
            tests++; if (errs != 0) fails++;
            chk("R12 rdy after last pop", data_rdy, 0);
        end
        // R3 clamp: byte 0x60 untouched by the 40-length write
        pb[0] = 8'h00; pb[1] = 8'd2; pb[2] = 8'h5F;
        cmd(8'h23, 3);
        pop(v); chk("R3 clamp last written", v, model[8'h5F]);
        pop(v); chk("R3 clamp beyond 32", v, model[8'h60]);
        // R4 length zero
        pb[1] = 8'd0; cmd(8'h23, 3);
        chk("R4 len0 no reply", data_rdy, 0);
        chk("R4 len0 data_out", data_out, 0);

        // R5 no image
        nv_write(8'd4, 8'h10, 9);
        chk("R5 nonv write inv", n_inv_cmd, 1);
        chk("R5 nonv write rdy", n_data_rdy, 0);
        pb[0] = 8'h00; pb[1] = 8'd4; pb[2] = 8'h10;
        cmd(8'h23, 3);
        chk("R5 nonv read inv", n_inv_cmd, 1);
        chk("R5 nonv read rdy", n_data_rdy, 0);
        chk("R5 image read ok rdy", data_rdy, 1);
        pop(v); chk("R4 after R5 byte", v, model[8'h10]);

        // R6/R7 lock sweep
        for (int cur = 0; cur < 2; cur++)
            for (int p1 = 0; p1 < 3; p1++)
                for (int b = 0; b < 2; b++) begin
                    logic exp_l;
                    set_lock(8'(cur), {7'b0, lock_m});
                    chk("R7 lock preset", mbox_lock, cur);
                    set_lock(8'(8'h10 | b), 8'(p1));
                    exp_l = (p1 == cur) ? b[0] : cur[0];
                    chk("R7 lock rule", mbox_lock, exp_l);
                    chk("R7 no reply", data_rdy, 0);
                    cmd(8'h28, 0);
                    pop(v); chk("R6 info tag", v, 8'h08);
                    chk("R6 second ready", data_rdy, 1);
                    pop(v); chk("R6 info lock", v, exp_l);
                    chk("R6 reply done", data_rdy, 0);
                end

        // R8 mailbox init
        pb[0] = 8'h05; pb[1] = 8'h12; pb[2] = 8'h34; pb[3] = 8'h56;
        cmd(8'h25, 4);
        chk("R8 count", mbox_count, 8'h05);
        chk("R8 addr", mbox_addr, 24'h123456);
        chk("R8 inited", mbox_inited, 1);
        chk("R8 init_stat clear", init_stat, 0);

        // R9 probe and unknown sweep
        cmd(8'h2C, 0);
        chk("R9 probe rdy", data_rdy, 1);
        pop(v); chk("R9 probe byte", v, 0);
        chk("R9 probe single", data_rdy, 0);
        for (int op = 0; op < 256; op++) begin
            if (op == 8'h22 || op == 8'h23 || op == 8'h24 || op == 8'h25 ||
                op == 8'h28 || op == 8'h29 || op == 8'h2C) continue;
            cmd(8'(op), 0);
            chk("R9 unknown inv", inv_cmd, 1);
            chk("R9 unknown rdy", data_rdy, 0);
        end

        // R10 / R11 interrupt code
        pb[0] = 8'h03; cmd(8'h24, 1);
        chk("R10 intr code", intr_code, 8'h04);
        chk("R10 no reply", data_rdy, 0);
        chk("R11 inv cleared by new op", inv_cmd, 0);
        cmd(8'h28, 0);
        chk("R11 intr cleared", intr_code, 0);
        // R11 new opcode drops unread reply
        cmd(8'h2C, 0);
        chk("R11 reply dropped by probe op", data_rdy, 1);
        pop(v); chk("R11 fresh reply byte", v, 0);
        // R11 restart mid-collection
        send_op(8'h23); send_par(8'h00);
        cmd(8'h28, 0);
        chk("R11 restart busy", busy, 0);
        pop(v); chk("R11 restart reply", v, 8'h08);
        pop(v);
        // R12 pop with nothing pending
        pop(v);
        chk("R12 idle pop data", v, 0);
        chk("R12 idle pop rdy", data_rdy, 0);
        cmd(8'h2C, 0);
        chk("R12 later reply intact", data_rdy, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule